// File: doc/BRIEF.md
# Per-Bit Ternary Lookup Unit

This block evaluates an arbitrary three-input Boolean function on every bit of a data word. At each bit position three operand bits are joined into a 3-bit index, and that index picks one bit of an 8-entry truth table. The truth table is bit k for index value k. The old destination value is one of the three inputs, and it is always the most significant index bit. So the unit works like a row of small FPGA lookup tables, all of which share one configuration.

A 2-bit mode selects where the table and the index bits come from:

- **Code 0:** the table is the 8-bit immediate.
- **Code 1:** the table is the low byte of a fourth register.
- **Code 2:** three byte lanes of one operand form the index. Each result is copied into the destination lanes that the lane mask enables.
- **Code 3:** the unit works on a 4-bit condition field held in the low bits of the words. Only the field positions that the mask enables are rewritten.

Instruction decoding lies outside the block. The caller presents decoded operands with a valid strobe. The result is registered and appears one cycle later, together with an output valid flag.

Top module: `tlut_unit`

## Requirements
- R1: In mode code 0, result bit i equals imm[k], where k = dst_in[i]*4 + opa[i]*2 + opb[i], for all 64 bits.
- R2: In mode code 1, the same per-bit index selects from opc[7:0], and opc bits 63..8 and imm have no effect on the result.
- R3: In mode code 2, index i (0..7) is opa[i]*4 + opa[8+i]*2 + opa[16+i]; the looked-up bit imm[index] is written to result bit i+8*j for each lane j in 0..2 with lane_mask[j] set, and lanes with lane_mask[j] clear take the dst_in bits.
- R4: In mode code 2, result bits 63..24 equal dst_in bits 63..24, and lane_mask[3] has no effect.
- R5: In mode code 3, the field BA=dst_in[3:0], BB=opa[3:0], BC=opb[3:0]; result bit i (0..3) is imm[BA[i]*4+BB[i]*2+BC[i]] when lane_mask[i] is set and BA[i] otherwise; result bits 63..4 equal dst_in bits 63..4.
- R6: A cycle with in_valid high loads the result register on that clock edge and raises out_valid for the following cycle only; a cycle with in_valid low makes out_valid low after the next edge.
- R7: While in_valid is low, result keeps its last value whatever the other inputs do.
- R8: After reset, out_valid is 0 and result is 0.
- R9: With imm = 0xCA in mode code 0, the result equals (opa & dst_in) | (opb & ~dst_in), a bitwise two-way select steered by dst_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 0 immediate table, 1 register table, 2 lane swizzle, 3 condition field |
| dst_in | input | 64 | Old destination value, most significant index input |
| opa | input | 64 | First operand; swizzle source in mode 2 |
| opb | input | 64 | Second operand, least significant index input |
| opc | input | 64 | Table register; low byte used in mode 1 |
| imm | input | 8 | Immediate truth table |
| lane_mask | input | 4 | Lane enables (mode 2, bits 0..2) or field bit enables (mode 3) |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered result; condition field in bits 3..0 in mode 3 |

## Verification
The bench targets index bit ordering first. A design that swapped the destination and operand roles in the index, or took the swizzle lanes in the wrong order, would give a result that differs from the model in mode 0 with asymmetric tables such as 0xCA and in mode 2 with distinct lane data. Masks are swept across every lane and field combination, including all-clear and the unused fourth mask bit. A merge that ignored the mask, or let bits above the lanes or field be overwritten, would corrupt bits that should follow dst_in. Register-table mode is driven with noisy upper opc bits and a misleading immediate, which exposes a wrong table source. Idle cycles with changing inputs expose a result register that loads without a strobe.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
   typedef enum logic [1:0] {
      TL_IMM  = 2'd0,
      TL_REG  = 2'd1,
      TL_LANE = 2'd2,
      TL_COND = 2'd3
   } tl_mode_e;
endpackage

// File: rtl/tlut_vec.sv
// Row of N identical 3-input lookups sharing one truth table.
module tlut_vec #(
   parameter int N       = 64,
   parameter int TABLE_W = 8
) (
   input  logic [TABLE_W-1:0] table_i,
   input  logic [N-1:0]       sel_hi,
   input  logic [N-1:0]       sel_mid,
   input  logic [N-1:0]       sel_lo,
   output logic [N-1:0]       out_o
);
   localparam int IDX_W = $clog2(TABLE_W);

   if (TABLE_W != 8) begin : g_bad_table
      $error("tlut_vec: TABLE_W must be 8 for a 3-input lookup");
   end
   if (N < 1) begin : g_bad_n
      $error("tlut_vec: N must be positive");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [IDX_W-1:0] idx;
      assign idx      = {sel_hi[g], sel_mid[g], sel_lo[g]};
      assign out_o[g] = table_i[idx];
   end
endmodule

// File: rtl/tlut_lane_merge.sv
// Swizzle mode: three byte lanes of one source form the index, result replicated into enabled lanes.
module tlut_lane_merge #(
   parameter int DATA_W  = 64,
   parameter int LANE_W  = 8,
   parameter int LANES   = 3,
   parameter int MASK_W  = 4,
   parameter int TABLE_W = 8
) (
   input  logic [DATA_W-1:0]  src_i,
   input  logic [DATA_W-1:0]  dst_i,
   input  logic [TABLE_W-1:0] table_i,
   input  logic [MASK_W-1:0]  mask_i,
   output logic [DATA_W-1:0]  merged_o
);
   localparam int USED_W = LANES * LANE_W;

   if (LANES != 3) begin : g_bad_lanes
      $error("tlut_lane_merge: three lanes are needed for a 3-bit index");
   end
   if (USED_W > DATA_W) begin : g_bad_width
      $error("tlut_lane_merge: lanes do not fit the data word");
   end
   if (MASK_W < LANES) begin : g_bad_mask
      $error("tlut_lane_merge: mask narrower than lane count");
   end

   logic [LANE_W-1:0] lane_res;

   tlut_vec #(.N(LANE_W), .TABLE_W(TABLE_W)) u_lut (
      .table_i (table_i),
      .sel_hi  (src_i[0*LANE_W +: LANE_W]),
      .sel_mid (src_i[1*LANE_W +: LANE_W]),
      .sel_lo  (src_i[2*LANE_W +: LANE_W]),
      .out_o   (lane_res)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign merged_o[j*LANE_W +: LANE_W] =
         mask_i[j] ? lane_res : dst_i[j*LANE_W +: LANE_W];
   end

   if (DATA_W > USED_W) begin : g_upper
      assign merged_o[DATA_W-1:USED_W] = dst_i[DATA_W-1:USED_W];
      logic unused_src_hi;
      assign unused_src_hi = ^src_i[DATA_W-1:USED_W];
   end
   if (MASK_W > LANES) begin : g_spare_mask
      logic unused_mask_hi;
      assign unused_mask_hi = ^mask_i[MASK_W-1:LANES];
   end
endmodule

// File: rtl/tlut_cond_merge.sv
// Condition-field mode: narrow field updated only where the mask allows.
module tlut_cond_merge #(
   parameter int DATA_W  = 64,
   parameter int FIELD_W = 4,
   parameter int MASK_W  = 4,
   parameter int TABLE_W = 8
) (
   input  logic [DATA_W-1:0]  fa_i,
   input  logic [DATA_W-1:0]  fb_i,
   input  logic [DATA_W-1:0]  fc_i,
   input  logic [TABLE_W-1:0] table_i,
   input  logic [MASK_W-1:0]  mask_i,
   output logic [DATA_W-1:0]  merged_o
);
   if (FIELD_W > MASK_W) begin : g_bad_mask
      $error("tlut_cond_merge: mask narrower than field");
   end
   if (FIELD_W >= DATA_W) begin : g_bad_field
      $error("tlut_cond_merge: field must be narrower than data word");
   end

   logic [FIELD_W-1:0] field_res;

   tlut_vec #(.N(FIELD_W), .TABLE_W(TABLE_W)) u_lut (
      .table_i (table_i),
      .sel_hi  (fa_i[FIELD_W-1:0]),
      .sel_mid (fb_i[FIELD_W-1:0]),
      .sel_lo  (fc_i[FIELD_W-1:0]),
      .out_o   (field_res)
   );

   for (genvar k = 0; k < FIELD_W; k++) begin : g_fbit
      assign merged_o[k] = mask_i[k] ? field_res[k] : fa_i[k];
   end
   assign merged_o[DATA_W-1:FIELD_W] = fa_i[DATA_W-1:FIELD_W];

   logic unused_fbc;
   assign unused_fbc = ^{fb_i[DATA_W-1:FIELD_W], fc_i[DATA_W-1:FIELD_W]};
   if (MASK_W > FIELD_W) begin : g_spare_mask
      logic unused_mask_hi;
      assign unused_mask_hi = ^mask_i[MASK_W-1:FIELD_W];
   end
endmodule

// File: rtl/tlut_unit.sv
module tlut_unit
   import tlut_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int TABLE_W = 8,
   parameter int LANE_W  = 8,
   parameter int LANES   = 3,
   parameter int FIELD_W = 4,
   parameter int MASK_W  = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] opc,
   input  logic [7:0]        imm,
   input  logic [MASK_W-1:0] lane_mask,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   localparam int LANE_TOP = LANES * LANE_W;

   if (TABLE_W != 8) begin : g_bad_table
      $error("tlut_unit: TABLE_W must be 8");
   end
   if (DATA_W < LANE_TOP || DATA_W <= TABLE_W) begin : g_bad_data
      $error("tlut_unit: DATA_W too small");
   end

   tl_mode_e mode_e;
   assign mode_e = tl_mode_e'(mode);

   // Wide path: immediate or register-sourced table.
   logic [TABLE_W-1:0] wide_table;
   logic [DATA_W-1:0]  wide_res;
   logic [DATA_W-1:0]  lane_res;
   logic [DATA_W-1:0]  cond_res;
   logic [DATA_W-1:0]  next_res;

   assign wide_table = (mode_e == TL_REG) ? opc[TABLE_W-1:0] : imm;

   tlut_vec #(.N(DATA_W), .TABLE_W(TABLE_W)) u_wide (
      .table_i (wide_table),
      .sel_hi  (dst_in),
      .sel_mid (opa),
      .sel_lo  (opb),
      .out_o   (wide_res)
   );

   tlut_lane_merge #(
      .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES),
      .MASK_W(MASK_W), .TABLE_W(TABLE_W)
   ) u_lane (
      .src_i    (opa),
      .dst_i    (dst_in),
      .table_i  (imm),
      .mask_i   (lane_mask),
      .merged_o (lane_res)
   );

   tlut_cond_merge #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W), .MASK_W(MASK_W), .TABLE_W(TABLE_W)
   ) u_cond (
      .fa_i     (dst_in),
      .fb_i     (opa),
      .fc_i     (opb),
      .table_i  (imm),
      .mask_i   (lane_mask),
      .merged_o (cond_res)
   );

   always_comb begin
      unique case (mode_e)
         TL_IMM, TL_REG: next_res = wide_res;
         TL_LANE:        next_res = lane_res;
         default:        next_res = cond_res;
      endcase
   end

   logic unused_opc_hi;
   assign unused_opc_hi = ^opc[DATA_W-1:TABLE_W];

   if (OUT_REG) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] res_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= next_res;
         end
      end

      assign out_valid = vld_q;
      assign result    = res_q;

      assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid)
         else $error("R6: out_valid missing after strobe");
      assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid)
         else $error("R6: out_valid without strobe");
      assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result))
         else $error("R7: result changed while idle");
      assert_cond_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == 2'd3) |=>
            (((result[FIELD_W-1:0] ^ $past(dst_in[FIELD_W-1:0]))
              & ~$past(lane_mask[FIELD_W-1:0])) == '0)
            && (result[DATA_W-1:FIELD_W] == $past(dst_in[DATA_W-1:FIELD_W])))
         else $error("R5: masked-off field bits altered");
      assert_lane_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == 2'd2 && lane_mask[LANES-1:0] == '0) |=>
            (result[LANE_TOP-1:0] == $past(dst_in[LANE_TOP-1:0])))
         else $error("R3: lanes written with empty mask");
      if (DATA_W > LANE_TOP) begin : g_upper_chk
         assert_lane_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 2'd2) |=>
               (result[DATA_W-1:LANE_TOP] == $past(dst_in[DATA_W-1:LANE_TOP])))
            else $error("R4: bits above lanes altered");
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = next_res;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end
endmodule

// File: tb/tlut_unit_tb.sv
`timescale 1ns/1ps
module tlut_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [63:0] dst_in = '0, opa = '0, opb = '0, opc = '0;
   logic [7:0]  imm = '0;
   logic [3:0]  lane_mask = '0;
   logic        out_valid;
   logic [63:0] result;

   int tests = 0;
   int fails = 0;

   logic        exp_valid = 1'b0;
   logic [63:0] exp_res = '0;

   always #2.5 clk = ~clk;

   tlut_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .dst_in(dst_in), .opa(opa), .opb(opb), .opc(opc), .imm(imm),
      .lane_mask(lane_mask), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] t,
         input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
         input logic [7:0] im, input logic [3:0] mk);
      logic [63:0] r;
      logic [7:0]  tbl;
      int k;
      r = t;
      if (m == 2'd0 || m == 2'd1) begin
         tbl = (m == 2'd1) ? c[7:0] : im;
         for (int i = 0; i < 64; i++) begin
            k = 4 * int'(t[i]) + 2 * int'(a[i]) + int'(b[i]);
            r[i] = tbl[k];
         end
      end else if (m == 2'd2) begin
         for (int i = 0; i < 8; i++) begin
            k = 4 * int'(a[i]) + 2 * int'(a[8+i]) + int'(a[16+i]);
            for (int j = 0; j < 3; j++)
               if (mk[j]) r[i + 8*j] = im[k];
         end
      end else begin
         for (int i = 0; i < 4; i++) begin
            k = 4 * int'(t[i]) + 2 * int'(a[i]) + int'(b[i]);
            if (mk[i]) r[i] = im[k];
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a negedge; drives, lets one edge pass, compares at the next negedge.
   task automatic step(input string req, input logic v, input logic [1:0] m,
         input logic [63:0] t, input logic [63:0] a, input logic [63:0] b,
         input logic [63:0] c, input logic [7:0] im, input logic [3:0] mk);
      in_valid = v; mode = m; dst_in = t; opa = a; opb = b; opc = c;
      imm = im; lane_mask = mk;
      @(posedge clk);
      if (v) exp_res = model(m, t, a, b, c, im, mk);
      exp_valid = v;
      @(negedge clk);
      check({req, " valid"}, {63'd0, out_valid}, {63'd0, exp_valid});
      check(req, result, exp_res);
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] t, a, b;
      repeat (3) @(negedge clk);
      check("R8 valid", {63'd0, out_valid}, 64'd0);
      check("R8 result", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: immediate tables, back-to-back strobes also cover R6
      step("R1 imm", 1, 2'd0, rnd64(), rnd64(), rnd64(), rnd64(), 8'hE8, 4'h0);
      step("R1 imm", 1, 2'd0, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00,
           64'hF0F0_F0F0_F0F0_F0F0, 64'h0, 8'h96, 4'h0);
      for (int n = 0; n < 8; n++)
         step("R1 imm", 1, 2'd0, rnd64(), rnd64(), rnd64(), rnd64(), 8'($urandom), 4'($urandom));
      step("R1 index order", 1, 2'd0, 64'hF0, 64'hCC, 64'hAA, 64'h0, 8'h01, 4'h0);

      // R2: register table, misleading imm and noisy upper opc
      for (int n = 0; n < 6; n++)
         step("R2 reg table", 1, 2'd1, rnd64(), rnd64(), rnd64(),
              {rnd64()}, 8'($urandom), 4'($urandom));
      step("R2 reg table", 1, 2'd1, 64'hF0F0, 64'hCCCC, 64'hAAAA,
           64'hFFFF_FFFF_FFFF_FF00, 8'hFF, 4'h0);

      // R3/R4: every lane mask including the unused top bit
      for (int mk = 0; mk < 16; mk++)
         step("R3 R4 lane", 1, 2'd2, rnd64(), rnd64(), rnd64(), rnd64(), 8'($urandom), 4'(mk));
      step("R3 lane order", 1, 2'd2, 64'h0, 64'h0000_0000_00AA_CCF0, 64'h0, 64'h0, 8'h02, 4'h7);

      // R5: condition field under every mask
      for (int mk = 0; mk < 16; mk++)
         step("R5 cond", 1, 2'd3, rnd64(), rnd64(), rnd64(), rnd64(), 8'($urandom), 4'(mk));

      // R9: 0xCA acts as a select steered by dst_in
      for (int n = 0; n < 4; n++) begin
         t = rnd64(); a = rnd64(); b = rnd64();
         step("R9 mix", 1, 2'd0, t, a, b, rnd64(), 8'hCA, 4'h0);
         check("R9 mux", result, (a & t) | (b & ~t));
      end

      // R7/R6: idle cycles with changing inputs leave the result alone
      for (int n = 0; n < 5; n++)
         step("R7 hold", 0, 2'($urandom), rnd64(), rnd64(), rnd64(), rnd64(),
              8'($urandom), 4'($urandom));
      step("R6 restart", 1, 2'd0, rnd64(), rnd64(), rnd64(), rnd64(), 8'h5A, 4'h0);
      step("R6 drop", 0, 2'd0, rnd64(), rnd64(), rnd64(), rnd64(), 8'h00, 4'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule